// File: doc/BRIEF.md
# Video Presence Detector with Fallback Timing

This block sits behind a sync extractor and decides whether a live video source is attached. Every clock, the sync extractor may pulse a strobe meaning "a horizontal sync was found on this line". The block times each line against the nominal line length of the current standard. When sixteen such line periods pass in a row with no strobe, it declares the source lost. When four strobes arrive in a row, each within one line length of the one before, it declares the source present again.

While no source is present, a free-running generator produces nominal line-start and frame-start pulses, so downstream logic keeps a stable raster. The generator uses the standard that was in force when video was last present. While video is present, the remembered standard follows the standard-select input. While video is absent, it is frozen. The 60 Hz standard uses 858 clocks by 525 lines and the 50 Hz standard uses 864 clocks by 625 lines. Both are parameters.

A small register interface holds a sticky status register at address 0xE and an interrupt mask at address 0xF. Each of them has a video-loss bit and a vertical-sync bit. The interrupt line is raised when a status bit and its mask bit are both set.

Top module: `vid_presence_det`

## Requirements
- R1: After reset the video-present flag is 0, the nominal-active flag is 1, status reads 0x00, mask reads 0x00 and the interrupt is 0.
- R2: The video-present flag rises on the clock edge that samples the 4th horizontal-sync strobe of an unbroken run. In a run, consecutive strobes are at most one line length (in clocks, of the remembered standard) apart.
- R3: A line period that ends without a strobe (a gap longer than one line length) restarts the count of R2 from zero.
- R4: While video is present, the flag falls exactly 16 line lengths after the last strobe. Any strobe before then restarts this count.
- R5: While video is absent, nom_hs_o pulses once every line length and nom_vs_o pulses together with nom_hs_o once every line length times lines per frame. Both pulses are high in the first cycle of absence, and both are 0 while video is present. nominal_active_o is the inverse of the present flag.
- R6: std_sel_i = 0 selects 858 clocks × 525 lines and 1 selects 864 × 625. The remembered standard tracks std_sel_i while video is present and ignores it while video is absent.
- R7: Status bit 6 becomes 1 on the edge at which video is declared lost. Status bit 0 becomes 1 on any edge that samples vs_det_i high. Both bits hold until cleared.
- R8: A write to address 0xE clears every status bit written as 1 and leaves the others unchanged. A set event in the same cycle wins over the clear.
- R9: The mask at address 0xF implements bits 6 and 0 only, and its other bits read 0. irq_o is 1 exactly when some status bit and its mask bit are both 1.
- R10: Reads of any address other than 0xE and 0xF return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_det_i | input | 1 | One-cycle strobe: horizontal sync detected |
| vs_det_i | input | 1 | One-cycle strobe: vertical sync detected |
| std_sel_i | input | 1 | Standard select, 0 = 60 Hz, 1 = 50 Hz |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| video_present_o | output | 1 | Source present |
| nominal_active_o | output | 1 | Fallback timing generator running |
| nom_hs_o | output | 1 | Generated line-start pulse |
| nom_vs_o | output | 1 | Generated frame-start pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench places strobes exactly one line length apart and then one clock further apart. An off-by-one in the line timeout would accept the wider gap or break the run on the exact one. It samples the present flag one clock before and at the 16th empty line, where an early or late loss would show. It also checks that a late strobe restarts that count. It measures generated line and frame periods for both standards, including after std_sel_i changes during absence, which a block that does not freeze the standard would follow. It also races a vertical-sync set against a write-one-to-clear, where a clear-wins design would drop the event.

// File: rtl/vpd_pkg.sv
package vpd_pkg;
  typedef enum logic {STD_60 = 1'b0, STD_50 = 1'b1} vid_std_e;

  localparam logic [3:0] ADDR_STAT = 4'hE;
  localparam logic [3:0] ADDR_MASK = 4'hF;
  localparam int         BIT_VS    = 0;
  localparam int         BIT_LOSS  = 6;
  localparam logic [7:0] IRQ_BITS  = 8'h41;
endpackage

// File: rtl/vpd_line_monitor.sv
module vpd_line_monitor
  import vpd_pkg::*;
#(
  parameter int LINE_60      = 858,
  parameter int LINE_50      = 864,
  parameter int LOSS_LINES   = 16,
  parameter int REGAIN_LINES = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     hs_det_i,
  input  vid_std_e std_i,
  output logic     present_o,
  output logic     loss_o
);
  localparam int LMAX = (LINE_60 > LINE_50) ? LINE_60 : LINE_50;
  localparam int LW   = $clog2(LMAX + 1);
  localparam int MW   = $clog2(LOSS_LINES + 1);
  localparam int HW   = $clog2(REGAIN_LINES + 1);
  localparam logic [LW-1:0] LAST_60 = LW'(LINE_60 - 1);
  localparam logic [LW-1:0] LAST_50 = LW'(LINE_50 - 1);
  localparam logic [MW-1:0] MISS_TOP = MW'(LOSS_LINES - 1);
  localparam logic [HW-1:0] HIT_TOP  = HW'(REGAIN_LINES - 1);

  logic [LW-1:0] lc_q;
  logic [MW-1:0] miss_q;
  logic [HW-1:0] hit_q;
  logic          present_q;
  logic          timeout;

  // >= so a switch to a shorter standard cannot strand the counter
  assign timeout = lc_q >= ((std_i == STD_50) ? LAST_50 : LAST_60);
  assign loss_o  = present_q && !hs_det_i && timeout && (miss_q == MISS_TOP);
  assign present_o = present_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lc_q      <= '0;
      miss_q    <= '0;
      hit_q     <= '0;
      present_q <= 1'b0;
    end else begin
      if (hs_det_i) begin
        lc_q   <= '0;
        miss_q <= '0;
        if (hit_q != HIT_TOP) hit_q <= hit_q + 1'b1;
        if (!present_q && hit_q == HIT_TOP) present_q <= 1'b1;
      end else if (timeout) begin
        lc_q  <= '0;
        hit_q <= '0;
        if (miss_q != MISS_TOP) miss_q <= miss_q + 1'b1;
        if (loss_o) present_q <= 1'b0;
      end else begin
        lc_q <= lc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vpd_nominal_gen.sv
module vpd_nominal_gen
  import vpd_pkg::*;
#(
  parameter int LINE_60  = 858,
  parameter int FRAME_60 = 525,
  parameter int LINE_50  = 864,
  parameter int FRAME_50 = 625
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  vid_std_e std_i,
  output logic     nom_hs_o,
  output logic     nom_vs_o
);
  localparam int LMAX = (LINE_60 > LINE_50) ? LINE_60 : LINE_50;
  localparam int FMAX = (FRAME_60 > FRAME_50) ? FRAME_60 : FRAME_50;
  localparam int CW   = $clog2(LMAX + 1);
  localparam int RW   = $clog2(FMAX + 1);

  logic [CW-1:0] col_q, col_last;
  logic [RW-1:0] row_q, row_last;

  assign col_last = (std_i == STD_50) ? CW'(LINE_50 - 1) : CW'(LINE_60 - 1);
  assign row_last = (std_i == STD_50) ? RW'(FRAME_50 - 1) : RW'(FRAME_60 - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else if (!run_i) begin
      col_q <= '0;
      row_q <= '0;
    end else if (col_q >= col_last) begin
      col_q <= '0;
      row_q <= (row_q >= row_last) ? '0 : row_q + 1'b1;
    end else begin
      col_q <= col_q + 1'b1;
    end
  end

  assign nom_hs_o = run_i && (col_q == '0);
  assign nom_vs_o = nom_hs_o && (row_q == '0);
endmodule

// File: rtl/vpd_irq_regs.sv
module vpd_irq_regs
  import vpd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       loss_set_i,
  input  logic       vs_set_i,
  output logic [7:0] rdata_o,
  output logic [7:0] stat_o,
  output logic [7:0] mask_o,
  output logic       irq_o
);
  logic [7:0] stat_q, mask_q, clr, set_v;

  always_comb begin
    clr = '0;
    if (we_i && addr_i == ADDR_STAT) clr = wdata_i;
    set_v = '0;
    set_v[BIT_LOSS] = loss_set_i;
    set_v[BIT_VS]   = vs_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= ((stat_q & ~clr) | set_v) & IRQ_BITS;  // set wins
      if (we_i && addr_i == ADDR_MASK) mask_q <= wdata_i & IRQ_BITS;
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_STAT: rdata_o = stat_q;
      ADDR_MASK: rdata_o = mask_q;
      default:   rdata_o = '0;
    endcase
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = |(stat_q & mask_q);
endmodule

// File: rtl/vid_presence_det.sv
module vid_presence_det
  import vpd_pkg::*;
#(
  parameter int LINE_60      = 858,
  parameter int FRAME_60     = 525,
  parameter int LINE_50      = 864,
  parameter int FRAME_50     = 625,
  parameter int LOSS_LINES   = 16,
  parameter int REGAIN_LINES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hs_det_i,
  input  logic       vs_det_i,
  input  logic       std_sel_i,
  input  logic       reg_we_i,
  input  logic [3:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       video_present_o,
  output logic       nominal_active_o,
  output logic       nom_hs_o,
  output logic       nom_vs_o,
  output logic       irq_o
);
  vid_std_e   std_q;
  logic       present, loss;
  logic [7:0] stat_q, mask_q;

  // remembered standard: follows input only while a source is present
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      std_q <= STD_60;
    else if (present) std_q <= vid_std_e'(std_sel_i);
  end

  vpd_line_monitor #(
    .LINE_60(LINE_60), .LINE_50(LINE_50),
    .LOSS_LINES(LOSS_LINES), .REGAIN_LINES(REGAIN_LINES)
  ) u_mon (
    .clk_i, .rst_ni, .hs_det_i, .std_i(std_q),
    .present_o(present), .loss_o(loss)
  );

  vpd_nominal_gen #(
    .LINE_60(LINE_60), .FRAME_60(FRAME_60),
    .LINE_50(LINE_50), .FRAME_50(FRAME_50)
  ) u_gen (
    .clk_i, .rst_ni, .run_i(!present), .std_i(std_q),
    .nom_hs_o, .nom_vs_o
  );

  vpd_irq_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .loss_set_i(loss), .vs_set_i(vs_det_i),
    .rdata_o(reg_rdata_o), .stat_o(stat_q), .mask_o(mask_q), .irq_o
  );

  assign video_present_o  = present;
  assign nominal_active_o = !present;
endmodule

// File: rtl/vid_presence_det_chk.sv
module vid_presence_det_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hs_det_i,
  input logic       vs_det_i,
  input logic       video_present_o,
  input logic       nom_hs_o,
  input logic       nom_vs_o,
  input logic       irq_o,
  input logic [7:0] stat_q,
  input logic [7:0] mask_q,
  input logic       std_q
);
  assert_rise_on_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(video_present_o) |-> $past(hs_det_i));

  assert_fall_without_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(video_present_o) |-> !$past(hs_det_i));

  assert_quiet_when_present_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    video_present_o |-> (!nom_hs_o && !nom_vs_o));

  assert_frame_on_line_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nom_vs_o |-> nom_hs_o);

  assert_std_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!video_present_o && !$past(video_present_o)) |-> $stable(std_q));

  assert_loss_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(video_present_o) |-> stat_q[6]);

  assert_vs_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_det_i |=> stat_q[0]);

  assert_irq_needs_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_q != 8'h00));
endmodule

bind vid_presence_det vid_presence_det_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hs_det_i(hs_det_i), .vs_det_i(vs_det_i),
  .video_present_o(video_present_o), .nom_hs_o(nom_hs_o), .nom_vs_o(nom_vs_o),
  .irq_o(irq_o), .stat_q(stat_q), .mask_q(mask_q), .std_q(std_q)
);

// File: tb/vid_presence_det_bench.sv
module vid_presence_det_bench;
  localparam int L60 = 12, F60 = 5, L50 = 16, F50 = 7;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       hs_det_i = 1'b0, vs_det_i = 1'b0, std_sel_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [3:0] reg_addr_i = 4'h0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       video_present_o, nominal_active_o, nom_hs_o, nom_vs_o, irq_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  vid_presence_det #(
    .LINE_60(L60), .FRAME_60(F60), .LINE_50(L50), .FRAME_50(F50),
    .LOSS_LINES(16), .REGAIN_LINES(4)
  ) u_vid_presence_det (.*);

  task automatic step(); @(posedge clk_i); #1; endtask

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_hs(); hs_det_i = 1'b1; step(); hs_det_i = 1'b0; endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d; step(); reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output int d);
    reg_addr_i = a; #1; d = int'(reg_rdata_o);
  endtask

  // R2: four strobes with the given edge spacing
  task automatic regain(int gap);
    for (int k = 0; k < 4; k++) begin
      if (k > 0) repeat (gap - 1) step();
      pulse_hs();
      check("R2 present after strobe", int'(video_present_o), (k == 3) ? 1 : 0);
    end
    check("R5 no line pulse while present", int'(nom_hs_o), 0);
    check("R5 nominal inactive", int'(nominal_active_o), 0);
  endtask

  // R4: last strobe edge was the previous step
  task automatic drop(int l);
    repeat (16 * l - 1) step();
    check("R4 present before 16th empty line", int'(video_present_o), 1);
    step();
    check("R4 lost at 16th empty line", int'(video_present_o), 0);
    check("R5 line pulse at loss", int'(nom_hs_o), 1);
    check("R5 frame pulse at loss", int'(nom_vs_o), 1);
    check("R5 nominal active", int'(nominal_active_o), 1);
  endtask

  task automatic measure(string tag, int l, int f);
    int c, hs_n, g;
    g = 0;
    while (!nom_vs_o && g < 4000) begin step(); g++; end
    step(); c = 1;
    while (!nom_hs_o && c < 4000) begin step(); c++; end
    check({tag, " line period"}, c, l);
    hs_n = 1;
    while (!nom_vs_o && c < 4000) begin step(); c++; if (nom_hs_o) hs_n++; end
    check({tag, " frame period"}, c, l * f);
    check({tag, " lines per frame"}, hs_n, f);
  endtask

  initial begin
    int d;
    int gaps[3] = '{1, 3, 12};
    step(); step();
    rst_ni = 1'b1;
    step();
    // R1
    check("R1 present", int'(video_present_o), 0);
    check("R1 nominal active", int'(nominal_active_o), 1);
    check("R1 irq", int'(irq_o), 0);
    rd(4'hE, d); check("R1 status", d, 0);
    rd(4'hF, d); check("R1 mask", d, 0);
    measure("R5 default std", L60, F60);

    // R2 / R4 / R5 / R6 sweep over both standards and spacings
    for (int s = 0; s < 2; s++) begin
      for (int gi = 0; gi < 3; gi++) begin
        std_sel_i = s[0];
        regain(gaps[gi]);
        drop(s == 1 ? L50 : L60);
        measure(s == 1 ? "R6 std 50" : "R6 std 60", s == 1 ? L50 : L60, s == 1 ? F50 : F60);
      end
    end

    // R3: gap of L+1 breaks the run (remembered std is 50 now, L = 16)
    pulse_hs(); step(); pulse_hs(); step(); pulse_hs();
    repeat (L50) step();
    pulse_hs();
    check("R3 run broken by empty line", int'(video_present_o), 0);
    step(); pulse_hs(); step(); pulse_hs();
    check("R3 three after restart", int'(video_present_o), 0);
    step(); pulse_hs();
    check("R3 fourth after restart", int'(video_present_o), 1);
    // R4 restart: strobe after 15 empty lines
    std_sel_i = 1'b1;
    repeat (15 * L50) step();
    pulse_hs();
    check("R4 late strobe keeps present", int'(video_present_o), 1);
    drop(L50);

    // R6: input ignored while absent
    std_sel_i = 1'b0;
    measure("R6 frozen while absent", L50, F50);

    // R7..R10 register behaviour
    rd(4'hE, d); check("R7 loss bit sticky", d, 8'h40);
    wr(4'hE, 8'hFF);
    rd(4'hE, d); check("R8 clear all", d, 0);
    wr(4'hF, 8'hFF);
    rd(4'hF, d); check("R9 mask implemented bits", d, 8'h41);
    check("R9 irq with no status", int'(irq_o), 0);
    rd(4'h3, d); check("R10 unmapped read", d, 0);
    rd(4'h0, d); check("R10 unmapped read 0", d, 0);
    vs_det_i = 1'b1; step(); vs_det_i = 1'b0;
    rd(4'hE, d); check("R7 vs bit", d, 8'h01);
    check("R9 irq on vs", int'(irq_o), 1);
    wr(4'hF, 8'h40);
    check("R9 irq masked", int'(irq_o), 0);
    wr(4'hE, 8'h00);
    rd(4'hE, d); check("R8 write zero no effect", d, 8'h01);
    reg_we_i = 1'b1; reg_addr_i = 4'hE; reg_wdata_i = 8'h01; vs_det_i = 1'b1;
    step(); reg_we_i = 1'b0; vs_det_i = 1'b0;
    rd(4'hE, d); check("R8 set wins over clear", d, 8'h01);
    wr(4'hE, 8'h01);
    rd(4'hE, d); check("R8 clear vs bit", d, 0);
    // loss event with mask on bit 6
    regain(2);
    drop(L60);
    rd(4'hE, d); check("R7 loss event sets bit 6", d, 8'h40);
    check("R9 irq on loss", int'(irq_o), 1);
    wr(4'hE, 8'h40);
    check("R8 irq after clear", int'(irq_o), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule